// File: doc/BRIEF.md
# Clocked Sequencer for Asynchronous Static RAM

This block sits between a synchronous request port and an asynchronous 16-bit static RAM. Each request is a single beat: an address, write data, two byte-lane enables and a direction flag, accepted on a valid/ready handshake. The block turns the request into a timed pin-level cycle on the RAM's address, chip select, two active-low lane selects, write strobe and output enable. It also controls a drive-enable for the shared data bus. On a read it captures the returned word and presents it for one clock with a result-valid pulse.

Each phase length is computed at elaboration from two parameters: the clock period in nanoseconds and a speed-grade selector (fast or slow). The nanosecond limits of the chosen grade are divided by the period and rounded up, and every phase lasts at least one clock. The fast grade uses a 45 ns write pulse, 50 ns address-to-end-of-write, 25 ns data setup, 55 ns write and read cycles, 55 ns address access, 30 ns output-enable access and 20 ns output release. The slow grade uses 55, 65, 30, 70, 70, 70, 35 and 25 ns for the same limits. A write has three parts: a setup clock with the strobe high, a strobe-low pulse and a recovery clock. A read holds output enable low for the read phase and samples on its last clock. The data-bus drive is held off until the RAM has had time to release the bus after a read.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held: req_ready is 1; sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n and sram_ub_n are 1; sram_dq_oe and rsp_valid are 0.
- R2: req_ready is 1 only when no access is in progress. A request is taken on a clock where req_valid and req_ready are both 1. req_ready is 0 on the clock after acceptance and stays 0 until the access ends.
- R3: A write holds sram_we_n low for exactly WR_LOW = max(ceil(pulse), ceil(address-to-end), ceil(data setup), 1) consecutive clocks. The clock before the strobe falls has sram_cs_n low and sram_we_n high. At 20 ns and the fast grade, WR_LOW is 3.
- R4: In a write, sram_cs_n stays low for the setup clock(s), the pulse and REC = max(1, ceil(write cycle) - 1 - WR_LOW) recovery clocks. That total is at least ceil(write cycle).
- R5: Lane enable bit 0 drives sram_lb_n low (data bits 7:0) and bit 1 drives sram_ub_n low (bits 15:8) during an access. A lane whose enable is 0 keeps its stored byte on a write.
- R6: A read holds sram_oe_n low, with sram_we_n high, for exactly RD_CYC = max(ceil(read cycle), ceil(address access), ceil(output-enable access), 1) clocks. The bus is sampled on the last of those clocks. rsp_valid is then 1 for exactly one clock and carries the sampled word. At 20 ns and the fast grade, RD_CYC is 3.
- R7: In rsp_rdata, a lane whose enable bit was 0 for that read returns all zeros.
- R8: sram_oe_n is high whenever sram_we_n is low or sram_dq_oe is 1.
- R9: sram_dq_oe rises only after sram_oe_n has been high for at least TA = ceil(output release) clocks (1 at 20 ns, fast grade).
- R10: sram_addr does not change while sram_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-clock read result strobe |
| rsp_rdata | output | DATA_W | Read result, disabled lanes zero |
| sram_addr | output | ADDR_W | RAM address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_lb_n | output | 1 | Low lane select, active low |
| sram_ub_n | output | 1 | High lane select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | DATA_W | Data toward the RAM |
| sram_dq_oe | output | 1 | Enable for the data-bus driver |
| sram_dq_in | input | DATA_W | Data from the RAM |

## Verification
The embedded properties check these on every cycle: the exact strobe-low and output-enable-low run lengths, the one-clock result pulse, the stable address while selected, the exclusion of output enable from drive and strobe, and the release gap before drive. Only the bench scenarios can show end-to-end behaviour. A behavioural RAM model returns garbage until the access time has passed, so it shows that data actually lands in the right lanes, that masked lanes keep their bytes, and that a read samples valid data.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSET   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WREC   = 3'd3,
    ST_READ   = 3'd4
  } seq_state_e;

  // nanosecond limits of one speed grade
  typedef struct packed {
    int unsigned wr_pulse;
    int unsigned wr_cycle;
    int unsigned wr_setup_end;
    int unsigned data_setup;
    int unsigned rd_cycle;
    int unsigned addr_acc;
    int unsigned oe_acc;
    int unsigned oe_release;
  } grade_t;

  function automatic grade_t grade_limits(input bit fast);
    grade_t g;
    if (fast) begin
      g.wr_pulse = 45; g.wr_cycle = 55; g.wr_setup_end = 50; g.data_setup = 25;
      g.rd_cycle = 55; g.addr_acc = 55; g.oe_acc = 30; g.oe_release = 20;
    end else begin
      g.wr_pulse = 55; g.wr_cycle = 70; g.wr_setup_end = 65; g.data_setup = 30;
      g.rd_cycle = 70; g.addr_acc = 70; g.oe_acc = 35; g.oe_release = 25;
    end
    return g;
  endfunction

  function automatic int unsigned clk_count(input int unsigned ns, input int unsigned period);
    int unsigned c;
    if (period == 0) return 1;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned wr_low_cycles(input bit fast, input int unsigned period);
    grade_t g = grade_limits(fast);
    return max2(clk_count(g.wr_pulse, period),
                max2(clk_count(g.wr_setup_end, period), clk_count(g.data_setup, period)));
  endfunction

  function automatic int unsigned rec_cycles(input bit fast, input int unsigned period);
    grade_t g = grade_limits(fast);
    int unsigned used = 1 + wr_low_cycles(fast, period);
    int unsigned wc   = clk_count(g.wr_cycle, period);
    return (wc > used + 1) ? (wc - used) : 1;
  endfunction

  function automatic int unsigned rd_cycles(input bit fast, input int unsigned period);
    grade_t g = grade_limits(fast);
    return max2(clk_count(g.rd_cycle, period),
                max2(clk_count(g.addr_acc, period), clk_count(g.oe_acc, period)));
  endfunction

  function automatic int unsigned ta_cycles(input bit fast, input int unsigned period);
    grade_t g = grade_limits(fast);
    return clk_count(g.oe_release, period);
  endfunction

endpackage

// File: rtl/sram_turnaround.sv
`timescale 1ns/1ps
module sram_turnaround #(
  parameter int CNT_W  = 4,
  parameter int TA_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_release,
  output logic ta_done
);

  logic [CNT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              wait_q <= '0;
    else if (oe_release)     wait_q <= CNT_W'(TA_CYC);
    else if (wait_q != '0)   wait_q <= wait_q - CNT_W'(1);
  end

  assign ta_done = (wait_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LANE_W = DATA_W / LANES;

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= sample;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        rsp_rdata[i*LANE_W +: LANE_W] <= '0;
      else if (sample)
        rsp_rdata[i*LANE_W +: LANE_W] <= lane_en[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
    end
  end

  // R6: result strobe lasts a single clock
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  parameter int WR_LOW = 3,
  parameter int REC    = 1,
  parameter int RD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  input  logic              ta_done,
  output logic              req_ready,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [1:0]        be_q,
  output logic              cs_act,
  output logic [1:0]        lane_act,
  output logic              we_act,
  output logic              oe_act,
  output logic              drive_act,
  output logic              rd_last
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             cnt_zero;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          state_q <= req_write ? ST_WSET : ST_READ;
          cnt_q   <= req_write ? '0 : CNT_W'(RD_CYC - 1);
        end
        ST_WSET: if (ta_done) begin
          state_q <= ST_WPULSE;
          cnt_q   <= CNT_W'(WR_LOW - 1);
        end
        ST_WPULSE: if (cnt_zero) begin
          state_q <= ST_WREC;
          cnt_q   <= CNT_W'(REC - 1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_WREC, ST_READ: if (cnt_zero) state_q <= ST_IDLE;
                          else          cnt_q   <= cnt_q - CNT_W'(1);
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign cs_act    = (state_q != ST_IDLE);
  assign lane_act  = cs_act ? be_q : 2'b00;
  assign we_act    = (state_q == ST_WPULSE);
  assign oe_act    = (state_q == ST_READ);
  assign drive_act = ((state_q == ST_WSET) && ta_done) ||
                     (state_q == ST_WPULSE) || (state_q == ST_WREC);
  assign rd_last   = (state_q == ST_READ) && cnt_zero;

  // run-length counters for the checks below
  logic [CNT_W:0] we_run_q, oe_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run_q <= '0;
      oe_run_q <= '0;
    end else begin
      we_run_q <= we_act ? we_run_q + (CNT_W+1)'(1) : '0;
      oe_run_q <= oe_act ? oe_run_q + (CNT_W+1)'(1) : '0;
    end
  end

  // R3: strobe-low run is exactly WR_LOW clocks
  p_we_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_act) |-> (we_run_q == (CNT_W+1)'(WR_LOW)));
  // R6: output-enable run is exactly RD_CYC clocks
  p_oe_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_act) |-> (oe_run_q == (CNT_W+1)'(RD_CYC)));
  // R2: no second acceptance right after one
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter bit FAST_GRADE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int WR_LOW  = int'(wr_low_cycles(FAST_GRADE, CLK_PERIOD_NS));
  localparam int REC     = int'(rec_cycles(FAST_GRADE, CLK_PERIOD_NS));
  localparam int RD_CYC  = int'(rd_cycles(FAST_GRADE, CLK_PERIOD_NS));
  localparam int TA_CYC  = int'(ta_cycles(FAST_GRADE, CLK_PERIOD_NS));
  localparam int MAX_CYC = int'(max2(max2(WR_LOW, REC), max2(RD_CYC, TA_CYC)));
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;
  localparam int GAP_W   = CNT_W + 1;

  logic [1:0]        be_q, lane_act;
  logic [DATA_W-1:0] wdata_q;
  logic              cs_act, we_act, oe_act, drive_act, rd_last, ta_done;

  sram_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .WR_LOW(WR_LOW), .REC(REC), .RD_CYC(RD_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .ta_done(ta_done),
    .req_ready(req_ready), .addr_q(sram_addr), .wdata_q(wdata_q), .be_q(be_q),
    .cs_act(cs_act), .lane_act(lane_act), .we_act(we_act), .oe_act(oe_act),
    .drive_act(drive_act), .rd_last(rd_last)
  );

  sram_turnaround #(.CNT_W(CNT_W), .TA_CYC(TA_CYC)) u_ta (
    .clk(clk), .rst_n(rst_n), .oe_release(rd_last), .ta_done(ta_done)
  );

  sram_rd_capture #(.DATA_W(DATA_W), .LANES(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample(rd_last), .lane_en(be_q),
    .dq_in(sram_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign sram_cs_n   = ~cs_act;
  assign sram_lb_n   = ~lane_act[0];
  assign sram_ub_n   = ~lane_act[1];
  assign sram_we_n   = ~we_act;
  assign sram_oe_n   = ~oe_act;
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = drive_act;

  // clocks since output enable was last low, saturating; starts saturated
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)              gap_q <= '1;
    else if (!sram_oe_n)     gap_q <= '0;
    else if (gap_q != '1)    gap_q <= gap_q + GAP_W'(1);
  end

  // R9: bus drive waits out the release time
  p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (gap_q >= GAP_W'(TA_CYC)));
  // R8: output enable never meets drive or strobe
  p_oe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe || !sram_we_n) |-> sram_oe_n);
  // R10: address held while selected
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

endmodule

// File: tb/sram_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;

  localparam int PERIOD = 20;
  localparam int AW = 17;
  localparam int DW = 16;
  localparam int ACCESS_NS = 55;

  // expected phase lengths, counted the slow way
  function automatic int up_cycles(input int ns);
    int c = 0;
    while (c * PERIOD < ns) c++;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int wr_exp, rd_exp, wc_exp, rec_exp, ta_exp;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid, sram_cs_n, sram_lb_n, sram_ub_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;

  always #(PERIOD/2) clk = ~clk;

  sram_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PERIOD), .FAST_GRADE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural RAM: data valid only after the access time
  logic [DW-1:0] mem [16];
  logic [DW-1:0] shadow [16];
  bit rd_ok = 0;
  always begin
    @(negedge sram_oe_n);
    rd_ok = 0;
    #(ACCESS_NS);
    rd_ok = !sram_oe_n;
  end
  always_comb begin
    if (!sram_cs_n && !sram_oe_n && rd_ok)
      sram_dq_in = {sram_ub_n ? 8'hA5 : mem[sram_addr[3:0]][15:8],
                    sram_lb_n ? 8'h5A : mem[sram_addr[3:0]][7:0]};
    else
      sram_dq_in = 16'hDEAD;
  end

  logic prev_we_n = 1, prev_cs_n = 1, prev_dq_oe = 0;
  int we_run = 0, cs_run = 0, oe_run = 0, gap = 100;
  bit saw_we = 0, addr_moved = 0;
  logic [AW-1:0] addr_start;
  logic [1:0] cur_be = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      // model write commit on strobe rise
      if (!prev_we_n && sram_we_n && !sram_cs_n) begin
        chk(sram_dq_oe, "R3 drive at strobe end", {31'd0, sram_dq_oe}, 1);
        if (!sram_lb_n) mem[sram_addr[3:0]][7:0]  = sram_dq_out[7:0];
        if (!sram_ub_n) mem[sram_addr[3:0]][15:8] = sram_dq_out[15:8];
      end
      // R3 strobe length and setup clock, R5 lanes, R8 exclusion
      if (!sram_we_n) begin
        if (prev_we_n) begin
          chk(!prev_cs_n, "R3 setup clock", {31'd0, prev_cs_n}, 0);
          chk({sram_ub_n, sram_lb_n} == ~cur_be, "R5 lane pins", {30'd0, sram_ub_n, sram_lb_n}, {30'd0, ~cur_be});
          chk(sram_oe_n, "R8 oe during strobe", {31'd0, sram_oe_n}, 1);
        end
        we_run++;
      end else if (we_run > 0) begin
        chk(we_run == wr_exp, "R3 strobe length", we_run, wr_exp);
        we_run = 0;
      end
      // R4 write select length, R10 address hold
      if (!sram_cs_n) begin
        if (prev_cs_n) begin addr_start = sram_addr; addr_moved = 0; end
        if (sram_addr != addr_start) addr_moved = 1;
        if (!sram_we_n) saw_we = 1;
        cs_run++;
      end else if (cs_run > 0) begin
        if (saw_we)
          chk(cs_run >= 1 + wr_exp + rec_exp && cs_run >= wc_exp, "R4 write cycle", cs_run, 1 + wr_exp + rec_exp);
        chk(!addr_moved, "R10 address hold", {31'd0, addr_moved}, 0);
        cs_run = 0; saw_we = 0;
      end
      // R6 read phase length
      if (!sram_oe_n) begin
        chk(sram_we_n, "R6 strobe high in read", {31'd0, sram_we_n}, 1);
        oe_run++;
      end else if (oe_run > 0) begin
        chk(oe_run == rd_exp, "R6 read length", oe_run, rd_exp);
        oe_run = 0;
      end
      // R9 turnaround
      if (!sram_oe_n) gap = 0; else if (gap < 100) gap++;
      if (sram_dq_oe && !prev_dq_oe) begin
        chk(gap - 1 >= ta_exp, "R9 turnaround", gap - 1, ta_exp);
        chk(sram_oe_n, "R8 oe during drive", {31'd0, sram_oe_n}, 1);
      end
      prev_we_n = sram_we_n; prev_cs_n = sram_cs_n; prev_dq_oe = sram_dq_oe;
    end
  end

  task automatic do_op(input bit wr, input int a, input logic [DW-1:0] d, input logic [1:0] be);
    int n;
    logic [DW-1:0] exp;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    cur_be = be;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R2 busy after accept", {31'd0, req_ready}, 0);
    if (wr) begin
      if (be[0]) shadow[a][7:0]  = d[7:0];
      if (be[1]) shadow[a][15:8] = d[15:8];
      n = 0;
      while (!req_ready && n < 50) begin @(negedge clk); n++; end
      chk(req_ready, "R2 ready after write", {31'd0, req_ready}, 1);
    end else begin
      exp = {be[1] ? shadow[a][15:8] : 8'h00, be[0] ? shadow[a][7:0] : 8'h00};
      n = 0;
      while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
      chk(rsp_valid, "R6 result strobe", {31'd0, rsp_valid}, 1);
      chk(rsp_rdata == exp, "R6 R7 read data", {16'd0, rsp_rdata}, {16'd0, exp});
      @(negedge clk);
      chk(!rsp_valid, "R6 single pulse", {31'd0, rsp_valid}, 0);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc == 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    wr_exp  = imax(up_cycles(45), imax(up_cycles(50), up_cycles(25)));
    rd_exp  = imax(up_cycles(55), imax(up_cycles(55), up_cycles(30)));
    wc_exp  = up_cycles(55);
    rec_exp = imax(1, wc_exp - 1 - wr_exp);
    ta_exp  = up_cycles(20);
    for (int i = 0; i < 16; i++) begin
      mem[i] = 16'(i * 16'h1111);
      shadow[i] = 16'(i * 16'h1111);
    end
    repeat (3) @(negedge clk);
    // R1 reset values
    chk({req_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe, rsp_valid} == 8'b11111100,
        "R1 reset outputs",
        {24'd0, req_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe, rsp_valid}, 32'hFC);
    rst_n = 1;
    // directed corners
    do_op(1, 3, 16'hBEEF, 2'b11);
    do_op(0, 3, 16'h0000, 2'b11);
    do_op(1, 3, 16'h1234, 2'b01);   // R5: high lane kept
    do_op(0, 3, 16'h0000, 2'b11);
    do_op(1, 3, 16'hAB00, 2'b10);
    do_op(0, 3, 16'h0000, 2'b01);   // R7: high lane masked
    do_op(0, 3, 16'h0000, 2'b10);   // R7: low lane masked
    do_op(1, 5, 16'hFFFF, 2'b00);   // R5: no lane written
    do_op(0, 5, 16'h0000, 2'b11);
    do_op(1, 15, 16'h0F0F, 2'b11);
    do_op(1, 0, 16'hC3C3, 2'b11);
    do_op(0, 15, 16'h0000, 2'b11);
    // random mix
    for (int k = 0; k < 80; k++) begin
      do_op(1'($urandom), int'($urandom % 16), 16'($urandom), 2'($urandom));
    end
    for (int k = 0; k < 16; k++) do_op(0, k, 16'h0000, 2'b11);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule